// File: doc/BRIEF.md
# Single-Line Serial Identifier Responder

This block is a slave on a single open-drain data line. It carries a fixed 64-bit identifier and hands it to a bus master. A system clock drives all of its timing, and the parameter `CYC_PER_US` gives the number of clock cycles in one microsecond. The block watches the line through a synchronizer. It pulls the line low through a single enable output, and the enable must drive an open-drain pad. A long low level from the master is taken as a bus reset, and the slave answers it with a presence pulse. It then shifts in an 8-bit command.

The command selects what follows. Two read codes make the slave stream its whole identifier. A search code makes it take part in bit-by-bit arbitration: for each bit it sends the bit, then the complement of the bit, and then reads back the direction the master chose. If that direction disagrees with its own bit, the slave drops out. Every other code leaves the slave silent until the next bus reset. The slave also treats a low level held past an abort threshold as the end of any transaction.

The identifier is built from a 48-bit serial-number parameter. A fixed family byte and a checksum byte are added around it when the design elaborates.

Top module: `ow_serial_slave`

## Requirements
- R1: The identifier has family code 01h in bits 7:0, the serial number in bits 55:8, and in bits 63:56 a CRC-8 with polynomial x^8+x^5+x^4+1. The CRC is reflected, starts from 0, and is taken over bits 55:0 with the lowest bit first. Running the same CRC over all 64 transmitted bits gives 0.
- R2: A low level of at least 480 µs counts as a bus reset. After the line rises, the slave waits 15–60 µs (nominally 30) and then pulls the line low for 60–240 µs (nominally 100).
- R3: In a write slot the slave samples the line 30 µs after the master's falling edge. Low reads as 0 and high reads as 1. Command bits arrive lowest bit first. A write-1 held low for 14 µs and a write-0 held low for 60 µs are both read correctly.
- R4: In a read slot a 0 bit is sent by pulling the line low for 15 µs from the master's falling edge. A 1 bit leaves the line released.
- R5: Command 33h and command 0Fh each make the slave send all 64 identifier bits, lowest bit first. After that the slave sends nothing more.
- R6: Command 55h, command CCh, and any other code except 33h, 0Fh and F0h leave the line released in every later slot until the next bus reset.
- R7: Command F0h starts a search. For each bit, lowest first, the slave sends the bit, then its complement, then samples the master's direction bit. When the direction matches, the slave moves on to the next bit. After the 64th bit it falls silent.
- R8: If the direction bit in a search disagrees with the slave's bit, the slave stays silent until the next bus reset.
- R9: A low level longer than 120 µs but shorter than 480 µs aborts any transaction. Later slots see no pull until a bus reset, and a bus reset still brings a presence pulse.
- R10: A bus reset in the middle of a transaction restarts the protocol. After presence, a new command is served from bit 0.
- R11: While `rst` is asserted, and after it is released, the pull output is low. The slave waits for a bus reset and answers no slot before one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `CYC_PER_US` cycles per microsecond |
| rst | input | 1 | Synchronous active-high reset |
| bus_i | input | 1 | Level sampled from the open-drain data line |
| bus_pull_o | output | 1 | High to pull the data line low |

## Verification
In a read slot carrying a 0, the slave's own pull starts while the master is still holding the line low. If that handover let the line rise for even one sample, the slave would see a second falling edge and shift its slot timing. The bench releases the master's low 3 µs after its falling edge, just after the slave has taken over. It then reads the identifier and the search bit-pairs back over many slots, so that any slip in slot timing shows up as a wrong bit in a later slot. A second overlap is a master reset that begins inside a slot, which starts a slot count, an abort count and a reset count together. The bench sends this pulse in the middle of a read and checks that presence follows and that the identifier restarts from bit 0.

// File: rtl/ow_pkg.sv
package ow_pkg;

    // Protocol timing, in microseconds
    localparam int unsigned T_RESET_US   = 480;
    localparam int unsigned T_ABORT_US   = 120;
    localparam int unsigned T_SAMPLE_US  = 30;
    localparam int unsigned T_DRIVE_US   = 15;
    localparam int unsigned T_PD_WAIT_US = 30;
    localparam int unsigned T_PD_LOW_US  = 100;

    localparam int unsigned ID_BITS  = 64;
    localparam int unsigned IDX_W    = $clog2(ID_BITS);
    localparam int unsigned CMD_BITS = 8;

    localparam logic [7:0] FAMILY_CODE = 8'h01;
    localparam logic [7:0] OP_READ_A   = 8'h33;
    localparam logic [7:0] OP_READ_B   = 8'h0F;
    localparam logic [7:0] OP_SEARCH   = 8'hF0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PD_WAIT,
        ST_PD_LOW,
        ST_CMD,
        ST_READ,
        ST_S_BIT,
        ST_S_CMP,
        ST_S_DIR
    } ow_state_e;

    // Events the line monitor hands to the sequencer
    typedef struct packed {
        logic rst_done;   // line rose after a full-length reset low
        logic abort;      // line low past the abort threshold
        logic samp;       // write-slot sample instant
        logic bitv;       // synchronized line level
        logic drive_win;  // inside the read-slot drive window
    } line_ev_t;

    // Reflected CRC-8 (x^8+x^5+x^4+1), lowest bit first, init 0
    function automatic logic [7:0] crc8_56(input logic [55:0] data);
        logic [7:0] c;
        logic       fb;
        c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            fb = c[0] ^ data[i];
            c  = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    function automatic logic [63:0] build_id(input logic [47:0] serial);
        logic [55:0] body;
        body = {serial, FAMILY_CODE};
        return {crc8_56(body), body};
    endfunction

    function automatic logic is_read_op(input logic [7:0] op);
        return (op == OP_READ_A) || (op == OP_READ_B);
    endfunction

endpackage

// File: rtl/ow_line_mon.sv
module ow_line_mon
    import ow_pkg::*;
#(
    parameter int unsigned CYC_PER_US  = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bus_i,
    output line_ev_t ev
);
    localparam int unsigned RST_CYC = T_RESET_US  * CYC_PER_US;
    localparam int unsigned ABT_CYC = T_ABORT_US  * CYC_PER_US;
    localparam int unsigned SMP_CYC = T_SAMPLE_US * CYC_PER_US;
    localparam int unsigned DRV_CYC = T_DRIVE_US  * CYC_PER_US;
    localparam int unsigned LOW_W   = $clog2(RST_CYC + 1);
    localparam int unsigned SLT_W   = $clog2(SMP_CYC + 2);
    localparam int unsigned SH_W    = SYNC_STAGES + 1;

    logic [SH_W-1:0]  sync_q;
    logic [LOW_W-1:0] low_cnt;
    logic [SLT_W-1:0] slot_cnt;
    logic             armed_q;
    logic             line_now, line_prev, fall, rise;

    assign line_now  = sync_q[SYNC_STAGES-1];
    assign line_prev = sync_q[SYNC_STAGES];
    assign fall      = line_prev & ~line_now;
    assign rise      = ~line_prev & line_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '1;
            low_cnt  <= '0;
            slot_cnt <= SLT_W'(SMP_CYC + 1);
            armed_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SH_W-2:0], bus_i};

            if (line_now)
                low_cnt <= '0;
            else if (low_cnt != LOW_W'(RST_CYC))
                low_cnt <= low_cnt + 1'b1;

            if (rise)
                armed_q <= 1'b0;
            else if (low_cnt == LOW_W'(RST_CYC))
                armed_q <= 1'b1;

            if (fall)
                slot_cnt <= '0;
            else if (slot_cnt != SLT_W'(SMP_CYC + 1))
                slot_cnt <= slot_cnt + 1'b1;
        end
    end

    always_comb begin
        ev.rst_done  = rise & armed_q;
        ev.abort     = (low_cnt == LOW_W'(ABT_CYC));
        ev.samp      = (slot_cnt == SLT_W'(SMP_CYC));
        ev.bitv      = line_now;
        ev.drive_win = (slot_cnt < SLT_W'(DRV_CYC));
    end

endmodule

// File: rtl/ow_rom_seq.sv
module ow_rom_seq
    import ow_pkg::*;
#(
    parameter int unsigned       CYC_PER_US = 4,
    parameter logic [ID_BITS-1:0] ID_VAL    = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         ev,
    output logic             pull_o,
    output ow_state_e        state_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam int unsigned PDW_CYC = T_PD_WAIT_US * CYC_PER_US;
    localparam int unsigned PDL_CYC = T_PD_LOW_US  * CYC_PER_US;
    localparam int unsigned PD_W    = $clog2(PDL_CYC + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_BITS - 1);
    localparam logic [IDX_W-1:0] LAST_CMD = IDX_W'(CMD_BITS - 1);

    ow_state_e          state;
    logic [IDX_W-1:0]   idx;
    logic [PD_W-1:0]    pd_cnt;
    logic [CMD_BITS-1:0] cmd_q;
    logic [CMD_BITS-1:0] cmd_next;
    logic               id_bit;
    logic               tx_zero;

    assign cmd_next = {ev.bitv, cmd_q[CMD_BITS-1:1]};
    assign id_bit   = ID_VAL[idx];

    always_comb begin
        case (state)
            ST_READ, ST_S_BIT: tx_zero = ~id_bit;
            ST_S_CMP:          tx_zero = id_bit;
            default:           tx_zero = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            pd_cnt <= '0;
            cmd_q  <= '0;
            pull_o <= 1'b0;
        end else begin
            pull_o <= (state == ST_PD_LOW) | (ev.drive_win & tx_zero);
            if (ev.rst_done) begin
                state  <= ST_PD_WAIT;
                pd_cnt <= '0;
            end else if (ev.abort) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_PD_WAIT: begin
                        pd_cnt <= pd_cnt + 1'b1;
                        if (pd_cnt == PD_W'(PDW_CYC - 1)) begin
                            state  <= ST_PD_LOW;
                            pd_cnt <= '0;
                        end
                    end
                    ST_PD_LOW: begin
                        pd_cnt <= pd_cnt + 1'b1;
                        if (pd_cnt == PD_W'(PDL_CYC - 1)) begin
                            state <= ST_CMD;
                            idx   <= '0;
                        end
                    end
                    ST_CMD: if (ev.samp) begin
                        cmd_q <= cmd_next;
                        idx   <= idx + 1'b1;
                        if (idx == LAST_CMD) begin
                            idx <= '0;
                            if (is_read_op(cmd_next))       state <= ST_READ;
                            else if (cmd_next == OP_SEARCH) state <= ST_S_BIT;
                            else                            state <= ST_IDLE;
                        end
                    end
                    ST_READ: if (ev.samp) begin
                        if (idx == LAST_IDX) state <= ST_IDLE;
                        else                 idx   <= idx + 1'b1;
                    end
                    ST_S_BIT: if (ev.samp) state <= ST_S_CMP;
                    ST_S_CMP: if (ev.samp) state <= ST_S_DIR;
                    ST_S_DIR: if (ev.samp) begin
                        if (ev.bitv != id_bit || idx == LAST_IDX) begin
                            state <= ST_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= ST_S_BIT;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign state_o = state;
    assign idx_o   = idx;

endmodule

// File: rtl/ow_serial_slave.sv
module ow_serial_slave
    import ow_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 4,
    parameter logic [47:0] SERIAL     = 48'h5A3C_96E1_0F2B
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_i,
    output logic bus_pull_o
);
    localparam logic [ID_BITS-1:0] ID_VAL = build_id(SERIAL);

    line_ev_t         ev;
    ow_state_e        state;
    logic [IDX_W-1:0] idx;

    ow_line_mon #(
        .CYC_PER_US (CYC_PER_US),
        .SYNC_STAGES(2)
    ) u_mon (
        .clk  (clk),
        .rst  (rst),
        .bus_i(bus_i),
        .ev   (ev)
    );

    ow_rom_seq #(
        .CYC_PER_US(CYC_PER_US),
        .ID_VAL    (ID_VAL)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .pull_o (bus_pull_o),
        .state_o(state),
        .idx_o  (idx)
    );

endmodule

// File: rtl/ow_serial_slave_chk.sv
module ow_serial_slave_chk
    import ow_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               pull,
    input line_ev_t           ev,
    input ow_state_e          state,
    input logic [IDX_W-1:0]   idx,
    input logic [ID_BITS-1:0] id_val
);
    localparam int unsigned PDL_CYC = T_PD_LOW_US * CYC_PER_US;
    localparam int unsigned RUN_W   = $clog2(PDL_CYC + 3);

    logic [RUN_W-1:0] pull_run;

    always_ff @(posedge clk) begin
        if (rst)                                pull_run <= '0;
        else if (!pull)                         pull_run <= '0;
        else if (pull_run != RUN_W'(PDL_CYC + 2)) pull_run <= pull_run + 1'b1;
    end

    // R2: no pull ever lasts longer than the presence pulse
    p_pull_bounded_r2: assert property (@(posedge clk) disable iff (rst)
        pull_run <= RUN_W'(PDL_CYC));

    // R2: the end of a reset low always starts the presence sequence
    p_reset_to_presence_r2: assert property (@(posedge clk) disable iff (rst)
        ev.rst_done |=> state == ST_PD_WAIT);

    // R9: a low longer than the abort threshold leaves the slave idle
    p_abort_idles_r9: assert property (@(posedge clk) disable iff (rst)
        ev.abort |=> state == ST_IDLE);

    // R6: an idle slave keeps the line released
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && $past(state == ST_IDLE)) |-> !pull);

    // R8: a wrong direction bit in a search drops the slave out
    p_search_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_S_DIR && ev.samp && ev.bitv != id_val[idx]) |=> state == ST_IDLE);

endmodule

bind ow_serial_slave ow_serial_slave_chk #(
    .CYC_PER_US(CYC_PER_US)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .pull  (bus_pull_o),
    .ev    (ev),
    .state (state),
    .idx   (idx),
    .id_val(ID_VAL)
);

// File: tb/tb_ow_serial_slave.sv
`timescale 1ns/1ps
module tb_ow_serial_slave;
    localparam int CLK_NS = 500;
    localparam int US     = 1000;
    localparam int CPU    = 2;
    localparam logic [47:0] SER = 48'hC4B2_7D19_E063;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_low = 1'b0;
    wire  pull_w;
    wire  line_w = !(m_low || pull_w);

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    logic [63:0] exp_id;

    always #(CLK_NS/2) clk = ~clk;

    ow_serial_slave #(.CYC_PER_US(CPU), .SERIAL(SER)) dut (
        .clk(clk), .rst(rst), .bus_i(line_w), .bus_pull_o(pull_w)
    );

    function automatic logic [7:0] ref_crc(input logic [63:0] v, input int n);
        logic [7:0] c = 8'h00;
        logic m;
        for (int i = 0; i < n; i++) begin
            m = c[0] ^ v[i];
            c = {m, c[7], c[6], c[5], c[4] ^ m, c[3] ^ m, c[2], c[1]};
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_reset(output int dly, output int len);
        m_low = 1'b1; #(500*US); m_low = 1'b0;
        dly = -1; len = 0;
        for (int t = 1; t <= 300; t++) begin
            #(US);
            if (!line_w) begin
                if (dly < 0) dly = t;
                len++;
            end
        end
    endtask

    task automatic wr_bit(input logic b, input int lo1, input int lo0);
        m_low = 1'b1;
        if (b) begin #(lo1*US); m_low = 1'b0; #((70-lo1)*US); end
        else   begin #(lo0*US); m_low = 1'b0; #(8*US); end
    endtask

    task automatic wr_byte(input logic [7:0] v, input int lo1 = 3, input int lo0 = 65);
        for (int i = 0; i < 8; i++) wr_bit(v[i], lo1, lo0);
    endtask

    task automatic rd_bits(input int n, output logic [63:0] v);
        v = '1;
        for (int i = 0; i < n; i++) begin
            m_low = 1'b1; #(3*US); m_low = 1'b0;
            #(9*US); v[i] = line_w;
            #(58*US);
        end
    endtask

    task automatic presence_ok(input string req);
        int d, l;
        bus_reset(d, l);
        check(d >= 15 && d <= 60, req, "presence delay", 64'(d), 64'd30);
        check(l >= 60 && l <= 240, req, "presence length", 64'(l), 64'd100);
    endtask

    task automatic t_reset_state();
        logic [63:0] v;
        check(pull_w == 1'b0, "R11", "pull after reset", 64'(pull_w), 64'd0);
        rd_bits(4, v);
        check(v[3:0] == 4'hF, "R11", "slots before bus reset", 64'(v[3:0]), 64'hF);
    endtask

    task automatic t_read(input logic [7:0] op, input int lo1, input int lo0, input string req);
        logic [63:0] v, tail;
        presence_ok("R2");
        wr_byte(op, lo1, lo0);
        rd_bits(64, v);
        check(v == exp_id, req, "identifier R4", v, exp_id);
        check(v[7:0] == 8'h01, "R1", "family byte", 64'(v[7:0]), 64'h01);
        check(ref_crc(v, 64) == 8'h00, "R1", "crc residue", 64'(ref_crc(v, 64)), 64'h0);
        rd_bits(8, tail);
        check(tail[7:0] == 8'hFF, "R5", "silent after 64 bits", 64'(tail[7:0]), 64'hFF);
    endtask

    task automatic t_silent(input logic [7:0] op);
        logic [63:0] v;
        presence_ok("R2");
        wr_byte(op);
        rd_bits(16, v);
        check(v[15:0] == 16'hFFFF, "R6", $sformatf("op %h silent", op), 64'(v[15:0]), 64'hFFFF);
    endtask

    task automatic t_search_full();
        logic [63:0] b, c, got, tail;
        int bad = 0;
        got = '0;
        presence_ok("R2");
        wr_byte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            rd_bits(1, b); rd_bits(1, c);
            if (b[0] != exp_id[i] || c[0] != ~exp_id[i]) bad++;
            got[i] = b[0];
            wr_bit(b[0], 3, 65);
        end
        check(bad == 0, "R7", "bit/complement pairs", 64'(bad), 64'd0);
        check(got == exp_id, "R7", "search result", got, exp_id);
        rd_bits(2, tail);
        check(tail[1:0] == 2'b11, "R7", "silent after search", 64'(tail[1:0]), 64'h3);
    endtask

    task automatic t_search_drop(input int k);
        logic [63:0] b, c, tail;
        presence_ok("R2");
        wr_byte(8'hF0);
        for (int i = 0; i < k; i++) begin
            rd_bits(1, b); rd_bits(1, c); wr_bit(b[0], 3, 65);
        end
        rd_bits(1, b); rd_bits(1, c);
        check(b[0] == exp_id[k] && c[0] == ~exp_id[k], "R7", "pair before drop",
              64'({b[0], c[0]}), 64'({exp_id[k], ~exp_id[k]}));
        wr_bit(~b[0], 3, 65);
        rd_bits(4, tail);
        check(tail[3:0] == 4'hF, "R8", "dropped after mismatch", 64'(tail[3:0]), 64'hF);
    endtask

    task automatic t_abort();
        logic [63:0] v;
        presence_ok("R2");
        wr_byte(8'h33);
        rd_bits(8, v);
        check(v[7:0] == exp_id[7:0], "R9", "first byte before abort", 64'(v[7:0]), 64'(exp_id[7:0]));
        m_low = 1'b1; #(200*US); m_low = 1'b0; #(20*US);
        rd_bits(8, v);
        check(v[7:0] == 8'hFF, "R9", "silent after abort", 64'(v[7:0]), 64'hFF);
        presence_ok("R9");
    endtask

    task automatic t_reset_mid();
        logic [63:0] v;
        presence_ok("R2");
        wr_byte(8'h33);
        rd_bits(20, v);
        presence_ok("R10");
        wr_byte(8'h33);
        rd_bits(64, v);
        check(v == exp_id, "R10", "restart from bit 0", v, exp_id);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        exp_id = {ref_crc({8'h00, SER, 8'h01}, 56), SER, 8'h01};
        repeat (5) @(posedge clk);
        #(CLK_NS/2);
        rst = 1'b0;
        #(10*US);
        t_reset_state();
        t_read(8'h33, 3, 65, "R5");
        t_read(8'h0F, 14, 60, "R3");
        t_silent(8'h55);
        t_silent(8'hCC);
        t_silent(8'hA5);
        t_search_full();
        t_search_drop(10);
        t_abort();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule